// File: doc/BRIEF.md
# Frame Display Configuration Latch

At every frame boundary this block captures the raw display size, mode and configuration register values and turns them into the geometry the scan-out path uses for the next frame. It produces the visible width in pixels, the visible height in lines, the distance in bytes between the starts of two rows, the pixel format, whether output is enabled, and whether the frame is blanked to a border colour. Fetching pixels and converting colours are handled by other blocks.

The raw register inputs may change at any time. The block looks at them only in the cycle where the frame-done strobe is high. It also compares the newly latched width, height and format against those of the previous latched frame. It raises a one-cycle pulse when any of the three differs, so that a downstream consumer can rebuild its output format only when that is needed.

Top module: `frame_cfg_latch`

## Requirements
- R1: After reset every output is zero: width, height, stride, format, enable, blank, border colour and the change pulse.
- R2: The size register packs three 10-bit fields: a word count minus one in bits 9:0, a line count minus one in bits 19:10 and a modulo field in bits 29:20. Stride in bytes = 4 × (words + modulo − 1).
- R3: The format code is mode-register bits 3:2. The codes are 0 = 16-bit ARGB1555, 1 = 16-bit RGB565, 2 = 24-bit RGB888 and 3 = 32-bit ARGB8888. The width in pixels is 2 × words for codes 0 and 1, floor(4 × words / 3) for code 2, and words for code 3.
- R4: The height is the line count, doubled when configuration bit 1 (interlace) is set.
- R5: Output is enabled only when mode bit 0 (display on) and configuration bit 0 (video out) are both set.
- R6: When bit 3 of the second configuration register is set, the blank output is high. The border colour output always carries the 24-bit border value captured with the frame.
- R7: The change pulse is high for exactly one cycle when the newly latched width, height or format differs from the previous latched frame. A change of stride, blank or border alone does not raise it.
- R8: All outputs change only in the cycle after a frame-done strobe. Register changes between strobes have no effect on the outputs.
- R9: On a strobe with output disabled, the enable output drops to zero. Width, height, stride, format, blank and border keep their previous values, and no change pulse is raised.
- R10: The divide-by-three result is exact for every word count from 1 to 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | Frame boundary strobe, one cycle |
| sizeReg | input | 30 | Raw size register |
| modeReg | input | 4 | Raw mode register |
| cfgReg | input | 2 | Raw configuration register |
| cfg2Reg | input | 4 | Raw second configuration register |
| borderReg | input | 24 | Raw border colour register |
| hPix | output | 12 | Latched width in pixels |
| vLines | output | 12 | Latched height in lines |
| rowStride | output | 13 | Latched row stride in bytes |
| pixFmt | output | 2 | Latched format code |
| dispEn | output | 1 | Output enabled for this frame |
| blanked | output | 1 | Frame blanked to border colour |
| borderColor | output | 24 | Latched border colour |
| fmtChanged | output | 1 | One-cycle format-change pulse |

## Verification
The sequence of frames steps through all four format codes, with and without interlace. This separates the shift-by-one, divide-by-three and pass-through width paths, and it exposes a wrong bit position for the format field. Frames that differ only in the modulo field, the blank bit or the border value must not raise the change pulse, while frames that differ only in format must raise it. These frames show that exactly width, height and format are compared. Frames with only one of the two enable bits set, and register changes with no strobe, show that the held state is preserved. A sweep of every word count through the 24-bit path checks the divider against true integer division.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [1:0] {
    FMT_ARGB1555 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGB888   = 2'd2,
    FMT_ARGB8888 = 2'd3
  } pixFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchEnable;  // refresh the enable flag
    logic latchGeom;    // capture geometry, format, blank, border
    logic raiseChange;  // emit the change pulse next cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/fcl_div3.sv
// Constant divide-by-three via reciprocal multiply: floor(num*K / 2^SH)
module fcl_div3 #(
  parameter int IN_W = 13
) (
  input  logic [IN_W-1:0] num,
  output logic [IN_W-1:0] quot
);
  localparam int SH = IN_W + 2;
  localparam longint KVAL = ((64'sd1 <<< SH) + 64'sd2) / 64'sd3;
  localparam logic [SH-1:0] K = KVAL[SH-1:0];
  localparam int PW = IN_W + SH;

  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(num) * PW'(K);
    quot = IN_W'(prod >> SH);
  end
endmodule

// File: rtl/fcl_datapath.sv
module fcl_datapath
  import fcl_pkg::*;
#(
  parameter int FIELD_W  = 10,
  parameter int BORDER_W = 24,
  parameter int EN_BIT   = 0,
  parameter int FMT_LSB  = 2,
  parameter int VO_BIT   = 0,
  parameter int IL_BIT   = 1,
  parameter int BLANK_BIT = 3,
  localparam int SIZE_W = 3 * FIELD_W,
  localparam int CNT_W  = FIELD_W + 1,
  localparam int H_W    = FIELD_W + 2,
  localparam int V_W    = FIELD_W + 2,
  localparam int S_W    = FIELD_W + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [SIZE_W-1:0]   sizeReg,
  input  logic [3:0]          modeReg,
  input  logic [1:0]          cfgReg,
  input  logic [3:0]          cfg2Reg,
  input  logic [BORDER_W-1:0] borderReg,
  output logic                enableNow,
  output logic                differs,
  output logic [H_W-1:0]      hPix,
  output logic [V_W-1:0]      vLines,
  output logic [S_W-1:0]      rowStride,
  output logic [1:0]          pixFmt,
  output logic                dispEn,
  output logic                blanked,
  output logic [BORDER_W-1:0] borderColor
);
  localparam int Q_W = H_W + 1;

  logic [FIELD_W-1:0] wordRaw, lineRaw, modRaw;
  logic [CNT_W-1:0]   words, lines, strideWords;
  logic [Q_W-1:0]     words4, words4Div3;
  pixFmt_e            fmtNext;
  logic [H_W-1:0]     hNext;
  logic [V_W-1:0]     vNext;
  logic [S_W-1:0]     sNext;

  logic [H_W-1:0]      hQ;
  logic [V_W-1:0]      vQ;
  logic [S_W-1:0]      sQ;
  logic [1:0]          fmtQ;
  logic                enQ, blankQ;
  logic [BORDER_W-1:0] borderQ;

  // field decode
  always_comb begin
    wordRaw     = sizeReg[FIELD_W-1:0];
    lineRaw     = sizeReg[2*FIELD_W-1:FIELD_W];
    modRaw      = sizeReg[3*FIELD_W-1:2*FIELD_W];
    words       = CNT_W'(wordRaw) + CNT_W'(1);
    lines       = CNT_W'(lineRaw) + CNT_W'(1);
    strideWords = words + CNT_W'(modRaw) - CNT_W'(1);
    fmtNext     = pixFmt_e'(modeReg[FMT_LSB +: 2]);
    enableNow   = modeReg[EN_BIT] & cfgReg[VO_BIT];
    words4      = Q_W'(words) << 2;
  end

  fcl_div3 #(.IN_W(Q_W)) u_div3 (
    .num  (words4),
    .quot (words4Div3)
  );

  // width per pixel format
  always_comb begin
    unique case (fmtNext)
      FMT_ARGB1555,
      FMT_RGB565:   hNext = H_W'(words) << 1;
      FMT_RGB888:   hNext = H_W'(words4Div3);
      default:      hNext = H_W'(words);
    endcase
  end

  // height and stride
  always_comb begin
    vNext = cfgReg[IL_BIT] ? (V_W'(lines) << 1) : V_W'(lines);
    sNext = S_W'(strideWords) << 2;
  end

  always_comb begin
    differs = (hNext != hQ) || (vNext != vQ) || (fmtNext != pixFmt_e'(fmtQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hQ      <= '0;
      vQ      <= '0;
      sQ      <= '0;
      fmtQ    <= '0;
      blankQ  <= 1'b0;
      borderQ <= '0;
    end else if (strobe.latchGeom) begin
      hQ      <= hNext;
      vQ      <= vNext;
      sQ      <= sNext;
      fmtQ    <= fmtNext;
      blankQ  <= cfg2Reg[BLANK_BIT];
      borderQ <= borderReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   enQ <= 1'b0;
    else if (strobe.latchEnable) enQ <= enableNow;
  end

  always_comb begin
    hPix        = hQ;
    vLines      = vQ;
    rowStride   = sQ;
    pixFmt      = fmtQ;
    dispEn      = enQ;
    blanked     = blankQ;
    borderColor = borderQ;
  end
endmodule

// File: rtl/fcl_control.sv
module fcl_control
  import fcl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameDone,
  input  logic        enableNow,
  input  logic        differs,
  output ctrlStrobe_t strobe,
  output logic        fmtChanged
);
  logic pulseQ;

  always_comb begin
    strobe.latchEnable = frameDone;
    strobe.latchGeom   = frameDone & enableNow;
    strobe.raiseChange = frameDone & enableNow & differs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= strobe.raiseChange;
  end

  assign fmtChanged = pulseQ;
endmodule

// File: rtl/frame_cfg_latch.sv
module frame_cfg_latch
  import fcl_pkg::*;
#(
  parameter int FIELD_W  = 10,
  parameter int BORDER_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameDone,
  input  logic [3*FIELD_W-1:0]      sizeReg,
  input  logic [3:0]                modeReg,
  input  logic [1:0]                cfgReg,
  input  logic [3:0]                cfg2Reg,
  input  logic [BORDER_W-1:0]       borderReg,
  output logic [FIELD_W+1:0]        hPix,
  output logic [FIELD_W+1:0]        vLines,
  output logic [FIELD_W+2:0]        rowStride,
  output logic [1:0]                pixFmt,
  output logic                      dispEn,
  output logic                      blanked,
  output logic [BORDER_W-1:0]       borderColor,
  output logic                      fmtChanged
);
  ctrlStrobe_t strobe;
  logic        enableNow, differs;

  fcl_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameDone  (frameDone),
    .enableNow  (enableNow),
    .differs    (differs),
    .strobe     (strobe),
    .fmtChanged (fmtChanged)
  );

  fcl_datapath #(
    .FIELD_W  (FIELD_W),
    .BORDER_W (BORDER_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sizeReg     (sizeReg),
    .modeReg     (modeReg),
    .cfgReg      (cfgReg),
    .cfg2Reg     (cfg2Reg),
    .borderReg   (borderReg),
    .enableNow   (enableNow),
    .differs     (differs),
    .hPix        (hPix),
    .vLines      (vLines),
    .rowStride   (rowStride),
    .pixFmt      (pixFmt),
    .dispEn      (dispEn),
    .blanked     (blanked),
    .borderColor (borderColor)
  );
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int FIELD_W  = 10,
  parameter int BORDER_W = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameDone,
  input logic [3:0]           modeReg,
  input logic [1:0]           cfgReg,
  input logic [3:0]           cfg2Reg,
  input logic [FIELD_W+1:0]   hPix,
  input logic [FIELD_W+1:0]   vLines,
  input logic [FIELD_W+2:0]   rowStride,
  input logic [1:0]           pixFmt,
  input logic                 dispEn,
  input logic                 blanked,
  input logic [BORDER_W-1:0]  borderColor,
  input logic                 fmtChanged
);
  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(hPix) && $stable(vLines) && $stable(rowStride) &&
                   $stable(pixFmt) && $stable(dispEn) && $stable(blanked) &&
                   $stable(borderColor) && !fmtChanged); // R8

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !(modeReg[0] && cfgReg[0]) |=> !dispEn && !fmtChanged &&
      $stable(hPix) && $stable(vLines) && $stable(pixFmt) && $stable(rowStride)); // R9

  AST_ENABLE_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && modeReg[0] && cfgReg[0] |=> dispEn); // R5

  AST_FMT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && modeReg[0] && cfgReg[0] |=> pixFmt == $past(modeReg[3:2])); // R3

  AST_INTERLACE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && modeReg[0] && cfgReg[0] && cfgReg[1] |=> !vLines[0]); // R4

  AST_BLANK_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && modeReg[0] && cfgReg[0] |=> blanked == $past(cfg2Reg[3])); // R6

  AST_CHANGE_MEANS_DIFF: assert property (@(posedge clk) disable iff (!rstN)
    fmtChanged |-> (hPix != $past(hPix)) || (vLines != $past(vLines)) ||
                   (pixFmt != $past(pixFmt))); // R7
endmodule

bind frame_cfg_latch fcl_checker #(.FIELD_W(FIELD_W), .BORDER_W(BORDER_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameDone   (frameDone),
  .modeReg     (modeReg),
  .cfgReg      (cfgReg),
  .cfg2Reg     (cfg2Reg),
  .hPix        (hPix),
  .vLines      (vLines),
  .rowStride   (rowStride),
  .pixFmt      (pixFmt),
  .dispEn      (dispEn),
  .blanked     (blanked),
  .borderColor (borderColor),
  .fmtChanged  (fmtChanged)
);

// File: tb/sim_frame_cfg_latch.sv
module sim_frame_cfg_latch;
  localparam int NV = 9;

  // stimulus: size, mode, cfg, cfg2, border
  localparam logic [29:0] V_SIZE [NV] = '{30'h00177C9F, 30'h00177C9F, 30'h00177C9F,
    30'h0003BDDF, 30'h00177E7F, 30'h00B77E7F, 30'h00000000, 30'h3FFFFFFF, 30'h00102404};
  localparam logic [3:0]  V_MODE [NV] = '{4'h5, 4'h1, 4'h1, 4'h9, 4'hD, 4'hD, 4'h9, 4'h9, 4'h9};
  localparam logic [1:0]  V_CFG  [NV] = '{2'h1, 2'h1, 2'h1, 2'h3, 2'h1, 2'h1, 2'h3, 2'h3, 2'h1};
  localparam logic [3:0]  V_CFG2 [NV] = '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h0, 4'h7, 4'h0, 4'h0};
  localparam logic [23:0] V_BORD [NV] = '{24'h0, 24'h0, 24'h123456, 24'h00ABCD, 24'h0,
    24'h0, 24'h0, 24'h0, 24'h0};
  // expected: width, height, stride, change pulse
  localparam int E_H [NV] = '{320, 320, 320, 640, 640, 640, 1, 1365, 6};
  localparam int E_V [NV] = '{480, 480, 480, 480, 480, 480, 2, 2048, 10};
  localparam int E_S [NV] = '{640, 640, 640, 1916, 2560, 2600, 0, 8184, 20};
  localparam int E_C [NV] = '{1, 1, 0, 1, 1, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 1'b0;
  logic [29:0] sizeReg = '0;
  logic [3:0]  modeReg = '0;
  logic [1:0]  cfgReg = '0;
  logic [3:0]  cfg2Reg = '0;
  logic [23:0] borderReg = '0;
  logic [11:0] hPix, vLines;
  logic [12:0] rowStride;
  logic [1:0]  pixFmt;
  logic        dispEn, blanked, fmtChanged;
  logic [23:0] borderColor;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  frame_cfg_latch u0 (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .sizeReg(sizeReg),
    .modeReg(modeReg), .cfgReg(cfgReg), .cfg2Reg(cfg2Reg), .borderReg(borderReg),
    .hPix(hPix), .vLines(vLines), .rowStride(rowStride), .pixFmt(pixFmt),
    .dispEn(dispEn), .blanked(blanked), .borderColor(borderColor),
    .fmtChanged(fmtChanged)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setRegs(input logic [29:0] s, input logic [3:0] m, input logic [1:0] c,
                         input logic [3:0] c2, input logic [23:0] b);
    sizeReg = s; modeReg = m; cfgReg = c; cfg2Reg = c2; borderReg = b;
  endtask

  // apply registers with a strobe; returns at the negedge after the latching edge
  task automatic frame(input logic [29:0] s, input logic [3:0] m, input logic [1:0] c,
                       input logic [3:0] c2, input logic [23:0] b);
    @(negedge clk);
    setRegs(s, m, c, c2, b);
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hPix", int'(hPix), 0);
    check("R1 vLines", int'(vLines), 0);
    check("R1 stride", int'(rowStride), 0);
    check("R1 fmt", int'(pixFmt), 0);
    check("R1 en", int'(dispEn), 0);
    check("R1 blank", int'(blanked), 0);
    check("R1 border", int'(borderColor), 0);
    check("R1 pulse", int'(fmtChanged), 0);
    rstN = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      frame(V_SIZE[i], V_MODE[i], V_CFG[i], V_CFG2[i], V_BORD[i]);
      check("R3 width", int'(hPix), E_H[i]);
      check("R4 height", int'(vLines), E_V[i]);
      check("R2 stride", int'(rowStride), E_S[i]);
      check("R3 format", int'(pixFmt), int'(V_MODE[i][3:2]));
      check("R5 enable", int'(dispEn), 1);
      check("R6 blank", int'(blanked), int'(V_CFG2[i][3]));
      check("R6 border", int'(borderColor), int'(V_BORD[i]));
      check("R7 pulse", int'(fmtChanged), E_C[i]);
      @(negedge clk);
      check("R7 pulse one cycle", int'(fmtChanged), 0);
    end

    // R9 display-on bit clear: hold width 6, height 10, stride 20, format 2
    frame(30'h00177E7F, 4'h8, 2'h1, 4'h8, 24'hFFFFFF);
    check("R9 en low", int'(dispEn), 0);
    check("R9 hold width", int'(hPix), 6);
    check("R9 hold height", int'(vLines), 10);
    check("R9 hold stride", int'(rowStride), 20);
    check("R9 hold blank", int'(blanked), 0);
    check("R9 no pulse", int'(fmtChanged), 0);
    // R9 / R5 video-out bit clear only
    frame(30'h00177E7F, 4'hD, 2'h2, 4'h0, 24'h0);
    check("R5 video-out off", int'(dispEn), 0);
    check("R9 hold fmt", int'(pixFmt), 2);
    check("R9 no pulse vo", int'(fmtChanged), 0);

    // R8 register changes without strobe
    @(negedge clk);
    setRegs(30'h3FFFFFFF, 4'h5, 2'h3, 4'h8, 24'h777777);
    repeat (3) @(negedge clk);
    check("R8 width stable", int'(hPix), 6);
    check("R8 en stable", int'(dispEn), 0);
    check("R8 border stable", int'(borderColor), 0);

    // R7 re-enable, same width/height/format, new stride only
    frame(30'h00302404, 4'h9, 2'h1, 4'h0, 24'h0);
    check("R5 re-enable", int'(dispEn), 1);
    check("R2 stride mod3", int'(rowStride), 28);
    check("R7 stride only no pulse", int'(fmtChanged), 0);
    // R7 format-only change raises pulse
    frame(30'h00302404, 4'hD, 2'h1, 4'h0, 24'h0);
    check("R3 8888 width", int'(hPix), 5);
    check("R7 fmt change pulse", int'(fmtChanged), 1);
    @(negedge clk);
    check("R7 pulse drops", int'(fmtChanged), 0);

    // R10 sweep every word count through the 24-bit path
    for (int w = 1; w <= 1024; w++) begin
      frame({10'd1, 10'd0, 10'(w - 1)}, 4'h9, 2'h1, 4'h0, 24'h0);
      check("R10 div3", int'(hPix), (4 * w) / 3);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule